// File: doc/BRIEF.md
# Precise Exception and Interrupt Recognizer

This block decides, every cycle, whether the core should raise an exception at the retirement point, and when to hand it to the handler. It watches four kinds of trigger. The first is an instruction-TLB miss that is visible only as a stalled fetch. The second is an external interrupt request. The third is a request to switch execution mode. The fourth is the state of the instruction at the head of the retirement queue. At most one trigger is recognised at a time, and its cause code is latched.

A recognised exception stays pending until the pipeline has drained: no operation is executing and the work queue is empty. The block then issues a single-cycle take pulse. The pulse carries the latched cause code and a delay-slot flag, which is the branch-pending state at that moment. Pending then clears. While the block waits for the drain, it counts the wait cycles. All pins are plain level control and status signals. Nothing here moves a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `exc_recog`

## Requirements
- R1: After reset, `exc_pending` and `take_pulse` are 0, `take_cause` is 0 and `wait_cycles` is 0.
- R2: With nothing pending, `fetch_itlb_stall` high and `head_valid` low, `exc_pending` is 1 from the next cycle and `take_cause` equals `fetch_cause` sampled at the recognising edge.
- R3: With `head_valid` high, a fetch ITLB stall is recognised only if the head is a branch (`head_is_branch`=1) that is non-speculative (`head_nonspec`=1). In every other case it is ignored.
- R4: With nothing pending and no ITLB trigger, an interrupt request (`irq_req`=1) is recognised when the head is interruptible, and `take_cause` becomes `irq_cause`.
- R5: The head is not interruptible when `head_valid` is 1 and either `head_unc_load_busy` (uncached buffered load with data in flight) or `head_split_issued` (issued split doubleword access) is 1. In that case the interrupt is not recognised.
- R6: A mode-switch request is recognised only when `retire_pc` < `KSEG_LIMIT` and `branch_pend`=0. Its cause is -2 in CW-bit two's complement (all ones except bit 0).
- R7: When several triggers apply in the same cycle, the ITLB trigger wins over the interrupt, and the interrupt wins over the mode switch. Only the winner is latched.
- R8: `take_pulse` is 1 exactly in cycles where an exception is pending and both `ops_busy` and `work_busy` are 0. `take_delay_slot` equals `branch_pend` in that cycle, and pending is 0 in the next cycle.
- R9: While an exception is pending, no new trigger is recognised and `take_cause` does not change.
- R10: Each cycle with an exception pending and the pipeline not drained increments `wait_cycles` by one, saturating at its maximum. Other cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | Retirement queue holds at least one entry |
| head_nonspec | input | 1 | Head entry is on the non-speculative path |
| head_is_branch | input | 1 | Head entry is a branch |
| head_unc_load_busy | input | 1 | Head is an uncached buffered load with data in flight |
| head_split_issued | input | 1 | Head is an issued split doubleword access |
| fetch_itlb_stall | input | 1 | Fetch stalled on an instruction-TLB miss |
| fetch_cause | input | CW | Cause code supplied by fetch for the miss |
| irq_req | input | 1 | Interrupt requested |
| irq_cause | input | CW | Cause code for the interrupt |
| switch_req | input | 1 | Mode-switch request |
| retire_pc | input | PCW | PC at the retirement point |
| branch_pend | input | 1 | A branch has retired and its delay slot has not |
| ops_busy | input | 1 | Operations still executing |
| work_busy | input | 1 | Work queue non-empty |
| exc_pending | output | 1 | An exception is latched and awaiting delivery |
| take_pulse | output | 1 | One-cycle handoff to the handler |
| take_cause | output | CW | Latched cause code |
| take_delay_slot | output | 1 | Delay-slot flag for the handoff |
| wait_cycles | output | WCW | Count of cycles spent waiting for drain |

## Verification
The embedded assertions check on every cycle that a take only happens on a drained pipeline, that it lasts one cycle and clears pending, that the cause stays still while pending, and that the wait counter steps correctly. They also check that an ITLB miss on an empty queue and a qualified switch request latch the right cause one edge later. Only the bench's scenarios can show that the priority among simultaneous triggers is right. The same holds for the interruptibility blocking and for a fetch stall under a speculative or non-branch head being ignored. The bench covers these with directed cases and a long mixed-stimulus run, compared against a behavioural model on every clock.

// File: rtl/exc_recog_pkg.sv
package exc_recog_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ITLB   = 2'd1,
    SRC_IRQ    = 2'd2,
    SRC_SWITCH = 2'd3
  } exc_src_e;
endpackage

// File: rtl/exc_head_gate.sv
module exc_head_gate (
  input  logic head_valid,
  input  logic head_nonspec,
  input  logic head_is_branch,
  input  logic head_unc_load_busy,
  input  logic head_split_issued,
  output logic itlb_window,
  output logic interruptible
);
  // ITLB miss is visible when the queue is empty, or when a committed
  // branch sits at the head (miss falls in its delay slot).
  assign itlb_window   = !head_valid || (head_nonspec && head_is_branch);
  assign interruptible = !(head_valid && (head_unc_load_busy || head_split_issued));
endmodule

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_recog_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          itlb_cond,
  input  logic          irq_cond,
  input  logic          sw_cond,
  input  logic [CW-1:0] fetch_cause,
  input  logic [CW-1:0] irq_cause,
  output logic          raise,
  output exc_src_e      src,
  output logic [CW-1:0] cause
);
  localparam logic [CW-1:0] SW_CODE = ~{{(CW-1){1'b0}}, 1'b1};

  always_comb begin
    src   = SRC_NONE;
    cause = '0;
    if (itlb_cond) begin
      src   = SRC_ITLB;
      cause = fetch_cause;
    end else if (irq_cond) begin
      src   = SRC_IRQ;
      cause = irq_cause;
    end else if (sw_cond) begin
      src   = SRC_SWITCH;
      cause = SW_CODE;
    end
  end
  assign raise = (src != SRC_NONE);
endmodule

// File: rtl/exc_wait_ctr.sv
module exc_wait_ctr #(
  parameter int WCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inc,
  output logic [WCW-1:0] count
);
  localparam logic [WCW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != CMAX) count <= count + 1'b1;
  end

  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count != CMAX) |=> (count == $past(count) + 1'b1)); // R10
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc) |=> $stable(count)); // R10
endmodule

// File: rtl/exc_recog.sv
module exc_recog
  import exc_recog_pkg::*;
#(
  parameter int              CW         = 5,
  parameter int              PCW        = 32,
  parameter int              WCW        = 16,
  parameter logic [PCW-1:0]  KSEG_LIMIT = 32'hC000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           head_valid,
  input  logic           head_nonspec,
  input  logic           head_is_branch,
  input  logic           head_unc_load_busy,
  input  logic           head_split_issued,
  input  logic           fetch_itlb_stall,
  input  logic [CW-1:0]  fetch_cause,
  input  logic           irq_req,
  input  logic [CW-1:0]  irq_cause,
  input  logic           switch_req,
  input  logic [PCW-1:0] retire_pc,
  input  logic           branch_pend,
  input  logic           ops_busy,
  input  logic           work_busy,
  output logic           exc_pending,
  output logic           take_pulse,
  output logic [CW-1:0]  take_cause,
  output logic           take_delay_slot,
  output logic [WCW-1:0] wait_cycles
);
  localparam logic [CW-1:0] SW_CODE = ~{{(CW-1){1'b0}}, 1'b1};

  logic          itlb_window, interruptible;
  logic          itlb_cond, irq_cond, sw_cond;
  logic          raise;
  exc_src_e      src;
  logic [CW-1:0] raise_cause;
  logic          drained;
  logic          pend_q;
  logic [CW-1:0] cause_q;

  exc_head_gate u_gate (
    .head_valid         (head_valid),
    .head_nonspec       (head_nonspec),
    .head_is_branch     (head_is_branch),
    .head_unc_load_busy (head_unc_load_busy),
    .head_split_issued  (head_split_issued),
    .itlb_window        (itlb_window),
    .interruptible      (interruptible)
  );

  assign itlb_cond = fetch_itlb_stall && itlb_window;
  assign irq_cond  = irq_req && interruptible;
  assign sw_cond   = switch_req && (retire_pc < KSEG_LIMIT) && !branch_pend;

  exc_cause_arb #(.CW(CW)) u_arb (
    .itlb_cond   (itlb_cond),
    .irq_cond    (irq_cond),
    .sw_cond     (sw_cond),
    .fetch_cause (fetch_cause),
    .irq_cause   (irq_cause),
    .raise       (raise),
    .src         (src),
    .cause       (raise_cause)
  );

  assign drained = !ops_busy && !work_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cause_q <= '0;
    end else if (pend_q) begin
      if (drained) pend_q <= 1'b0;
    end else if (raise) begin
      pend_q  <= 1'b1;
      cause_q <= raise_cause;
    end
  end

  assign exc_pending     = pend_q;
  assign take_pulse      = pend_q && drained;
  assign take_cause      = cause_q;
  assign take_delay_slot = take_pulse && branch_pend;

  exc_wait_ctr #(.WCW(WCW)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (pend_q && !drained),
    .count (wait_cycles)
  );

  AST_TAKE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> (!ops_busy && !work_busy)); // R8
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |=> (!exc_pending && !take_pulse)); // R8
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pending |=> $stable(take_cause)); // R9
  AST_ITLB_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_pending && fetch_itlb_stall && !head_valid) |=>
      (exc_pending && take_cause == $past(fetch_cause))); // R2
  AST_SWITCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_pending && switch_req && retire_pc < KSEG_LIMIT && !branch_pend &&
     !fetch_itlb_stall && !irq_req) |=> (exc_pending && take_cause == SW_CODE)); // R6
endmodule

// File: tb/exc_recog_bench.sv
module exc_recog_bench;
  localparam int CW = 5;
  localparam int PCW = 32;
  localparam int WCW = 16;
  localparam logic [PCW-1:0] KLIM = 32'hC000_0000;
  localparam logic [CW-1:0] SWC = 5'b11110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_valid, head_nonspec, head_is_branch, head_unc_load_busy, head_split_issued;
  logic fetch_itlb_stall, irq_req, switch_req, branch_pend, ops_busy, work_busy;
  logic [CW-1:0] fetch_cause, irq_cause;
  logic [PCW-1:0] retire_pc;
  logic exc_pending, take_pulse, take_delay_slot;
  logic [CW-1:0] take_cause;
  logic [WCW-1:0] wait_cycles;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit m_pend = 0;
  int m_cause = 0;
  int m_wait = 0;

  always #10 clk = ~clk;

  exc_recog #(.CW(CW), .PCW(PCW), .WCW(WCW), .KSEG_LIMIT(KLIM)) u_exc_recog (
    .clk(clk), .rst_n(rst_n),
    .head_valid(head_valid), .head_nonspec(head_nonspec), .head_is_branch(head_is_branch),
    .head_unc_load_busy(head_unc_load_busy), .head_split_issued(head_split_issued),
    .fetch_itlb_stall(fetch_itlb_stall), .fetch_cause(fetch_cause),
    .irq_req(irq_req), .irq_cause(irq_cause), .switch_req(switch_req),
    .retire_pc(retire_pc), .branch_pend(branch_pend),
    .ops_busy(ops_busy), .work_busy(work_busy),
    .exc_pending(exc_pending), .take_pulse(take_pulse), .take_cause(take_cause),
    .take_delay_slot(take_delay_slot), .wait_cycles(wait_cycles)
  );

  task automatic idle_in();
    head_valid = 0; head_nonspec = 0; head_is_branch = 0;
    head_unc_load_busy = 0; head_split_issued = 0;
    fetch_itlb_stall = 0; fetch_cause = 5'd3; irq_req = 0; irq_cause = 5'd9;
    switch_req = 0; retire_pc = 32'h0000_1000; branch_pend = 0;
    ops_busy = 0; work_busy = 0;
  endtask

  // compare the DUT against the model for the current cycle, then advance
  task automatic step(input string tag);
    bit drained, e_take, e_ds;
    #2;
    drained = !ops_busy && !work_busy;
    e_take = m_pend && drained;
    e_ds = e_take && branch_pend;
    checks++;
    if (exc_pending !== m_pend || take_pulse !== e_take || take_delay_slot !== e_ds ||
        int'(take_cause) != m_cause || int'(wait_cycles) != m_wait) begin
      errors++;
      $display("FAIL %s: got pend=%0b take=%0b ds=%0b cause=%0d wait=%0d, expected pend=%0b take=%0b ds=%0b cause=%0d wait=%0d",
               tag, exc_pending, take_pulse, take_delay_slot, take_cause, wait_cycles,
               m_pend, e_take, e_ds, m_cause, m_wait);
    end
    if (m_pend) begin
      if (drained) m_pend = 0;
      else if (m_wait < 65535) m_wait++;
    end else begin
      if (fetch_itlb_stall && (!head_valid || (head_nonspec && head_is_branch))) begin
        m_pend = 1; m_cause = fetch_cause;
      end else if (irq_req && !(head_valid && (head_unc_load_busy || head_split_issued))) begin
        m_pend = 1; m_cause = irq_cause;
      end else if (switch_req && retire_pc < KLIM && !branch_pend) begin
        m_pend = 1; m_cause = SWC;
      end
    end
    @(negedge clk);
  endtask

  // let any pending exception drain with idle inputs
  task automatic flush(input string tag);
    idle_in();
    step(tag);
    step(tag);
  endtask

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    step("R1");

    // R2: empty queue ITLB miss, held through busy cycles (R10), then delivered (R8)
    fetch_itlb_stall = 1; fetch_cause = 5'd17; ops_busy = 1;
    step("R2");
    fetch_itlb_stall = 0; step("R10");
    work_busy = 1; ops_busy = 0; step("R10");
    work_busy = 0; branch_pend = 1; step("R8");
    flush("R8");

    // R3: head cases
    head_valid = 1; head_nonspec = 1; head_is_branch = 1;
    fetch_itlb_stall = 1; fetch_cause = 5'd6; step("R3");
    flush("R3");
    head_valid = 1; head_nonspec = 1; head_is_branch = 0; fetch_itlb_stall = 1; step("R3");
    step("R3");
    head_nonspec = 0; head_is_branch = 1; step("R3");
    flush("R3");

    // R4 / R5
    head_valid = 1; irq_req = 1; irq_cause = 5'd0; step("R4");
    flush("R4");
    head_valid = 1; head_unc_load_busy = 1; irq_req = 1; step("R5");
    step("R5");
    head_unc_load_busy = 0; head_split_issued = 1; step("R5");
    head_valid = 0; step("R5");
    flush("R5");

    // R6
    switch_req = 1; retire_pc = KLIM - 1; step("R6");
    flush("R6");
    switch_req = 1; retire_pc = KLIM; step("R6");
    retire_pc = 32'h10; branch_pend = 1; step("R6");
    flush("R6");

    // R7: priority
    fetch_itlb_stall = 1; irq_req = 1; switch_req = 1; fetch_cause = 5'd21; step("R7");
    flush("R7");
    irq_req = 1; switch_req = 1; irq_cause = 5'd2; step("R7");
    flush("R7");

    // R9: triggers present while pending and undrained
    irq_req = 1; irq_cause = 5'd12; ops_busy = 1; step("R9");
    fetch_itlb_stall = 1; switch_req = 1; step("R9");
    step("R9");
    ops_busy = 0; step("R9");
    flush("R9");

    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      head_valid = r[0]; head_nonspec = r[1]; head_is_branch = r[2];
      head_unc_load_busy = r[3] & r[4]; head_split_issued = r[5] & r[6];
      fetch_itlb_stall = r[7] & r[8] & r[9]; fetch_cause = r[14:10];
      irq_req = r[15] & r[16]; irq_cause = r[21:17];
      switch_req = r[22] & r[23]; retire_pc = r[24] ? 32'hD000_0000 : 32'h0000_4000;
      branch_pend = r[25] & r[26]; ops_busy = r[27]; work_busy = r[28] & r[29];
      step("R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule